// File: doc/BRIEF.md
# Masked Interrupt Cause Controller

This block collects up to 32 level-sensitive interrupt requests into one interrupt line for a processor or a parent controller. Each source owns one bit in a cause register and one bit in an enable mask. An active source sets its cause bit. The cause bit stays set until software clears it by writing a one to it. A line counts as pending only when its cause bit and its mask bit are both set. The combined output is raised whenever any line is pending.

Software reaches both registers through a small synchronous 32-bit read/write port. Offset 0x0 holds the cause register and offset 0x4 holds the mask. A handler reads the lowest-pending-index output, services that line, and then acknowledges it. If the source is still asserted when it is acknowledged, the cause bit is set again at once. To shut the block down, software clears the mask and then writes all ones to the cause register.

Top module: `mcause_intc`

## Requirements
- R1: After reset, the cause register, the mask register, `irq_o`, `pend_vld_o`, `pend_idx_o` and `rdata_o` are all 0.
- R2: A write to byte offset 0x4 replaces the whole mask register with `wdata_i`. A read of offset 0x4 returns the mask.
- R3: A write to byte offset 0x0 clears every cause bit whose `wdata_i` bit is 1. Cause bits whose `wdata_i` bit is 0 keep their value.
- R4: A high `src_i[n]` sets cause bit n at the next clock edge. If the source is high in the same cycle that its cause bit is acknowledged, the set wins and the bit stays 1.
- R5: `irq_o` is a register that equals the OR over all lines of (cause AND mask), one clock after the registers change.
- R6: `pend_idx_o` gives the lowest bit number n at which both cause and mask are 1, and `pend_vld_o` is then 1. When no bit is set in both, `pend_vld_o` is 0 and `pend_idx_o` is 0. The mask has no effect on what the cause register holds.
- R7: The read data is registered. `rdata_o` shows the addressed register one clock after a read strobe and holds that value until the next read. A read of offset 0x8, offset 0xC or a non-word-aligned address returns 0. A write to any of these addresses changes nothing.
- R8: After the shutdown sequence (write 0 to the mask, then all ones to the cause register), `irq_o` is 0 and the only cause bits set are those whose sources are still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | 32 | Level-sensitive interrupt sources, one per line |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read (valid with `sel_i`) |
| addr_i | input | 4 | Byte address; 0x0 = cause, 0x4 = mask |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| pend_idx_o | output | 5 | Lowest-numbered line that is both pending and enabled |
| pend_vld_o | output | 1 | 1 when `pend_idx_o` names a real pending line |

## Verification
The sweeps below use the following input patterns:

- **Single-source sweep.** One line at a time raises its source while the mask is fully open. This confirms that each line reaches its own cause bit, index and output, and does not reach any other line.
- **Shifted multi-bit patterns.** A second sweep places a bit pattern whose lowest set bit walks from 0 to 31. It shows that the lowest line wins and no higher line wins.
- **Partial masks.** Cause patterns are placed under masks that cover only part of them. This separates what the cause register holds from what is pending.
- **Ordering cases.** Partial acknowledges, acknowledges while the source is held high, the shutdown sequence, and accesses to unmapped offsets. These show the write-one-to-clear rule, the set-wins rule and the rule that unmapped accesses are ignored.

// File: rtl/mcause_intc_pkg.sv
package mcause_intc_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned SLOT_LSB = 2;

  typedef enum logic [1:0] {
    SLOT_CAUSE = 2'd0,
    SLOT_MASK  = 2'd1,
    SLOT_RSV2  = 2'd2,
    SLOT_RSV3  = 2'd3
  } reg_slot_e;
endpackage

// File: rtl/mcause_rst_sync.sv
module mcause_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/mcause_cause_bank.sv
module mcause_cause_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               ack_en_i,
  input  logic [NUM_SRC-1:0] ack_bits_i,
  output logic [NUM_SRC-1:0] cause_o
);
  logic [NUM_SRC-1:0] cause_q;
  logic [NUM_SRC-1:0] cause_n;
  logic [NUM_SRC-1:0] clr_bits;

  always_comb begin
    clr_bits = ack_en_i ? ack_bits_i : '0;
    // a level still present re-sets the bit in the same cycle it is cleared
    cause_n  = (cause_q & ~clr_bits) | src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_n;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/mcause_mask_reg.sv
module mcause_mask_reg #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_n;

  always_comb begin
    mask_n = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_en_i) mask_q <= mask_n;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/mcause_lowest_pick.sv
module mcause_lowest_pick #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               vld_o
);
  logic [NUM_SRC:0]   seen;
  logic [NUM_SRC-1:0] first;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign first[g]    = req_i[g] & ~seen[g];
    assign seen[g + 1] = seen[g] | req_i[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (first[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign vld_o = seen[NUM_SRC];
endmodule

// File: rtl/mcause_intc.sv
module mcause_intc
  import mcause_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_o,
  output logic [IDX_W-1:0]   pend_idx_o,
  output logic               pend_vld_o
);
  logic               rst_sync_n;
  logic               aligned;
  reg_slot_e          slot;
  logic               cause_wr;
  logic               mask_wr;
  logic               rd_en;
  logic [NUM_SRC-1:0] cause_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] rdata_q;
  logic [NUM_SRC-1:0] rdata_n;
  logic               irq_q;
  logic               irq_n;

  mcause_rst_sync rst_sync_i (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  always_comb begin
    aligned  = (addr_i[SLOT_LSB-1:0] == '0);
    slot     = reg_slot_e'(addr_i[SLOT_LSB +: 2]);
    cause_wr = sel_i & wr_i & aligned & (slot == SLOT_CAUSE);
    mask_wr  = sel_i & wr_i & aligned & (slot == SLOT_MASK);
    rd_en    = sel_i & ~wr_i;
  end

  mcause_cause_bank #(.NUM_SRC(NUM_SRC)) cause_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .src_i      (src_i),
    .ack_en_i   (cause_wr),
    .ack_bits_i (wdata_i),
    .cause_o    (cause_q)
  );

  mcause_mask_reg #(.NUM_SRC(NUM_SRC)) mask_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en_i (mask_wr),
    .wdata_i (wdata_i),
    .mask_o  (mask_q)
  );

  assign pend = cause_q & mask_q;

  mcause_lowest_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) pick_i (
    .req_i (pend),
    .idx_o (pend_idx_o),
    .vld_o (pend_vld_o)
  );

  always_comb begin
    irq_n   = |pend;
    rdata_n = '0;
    if (aligned) begin
      case (slot)
        SLOT_CAUSE: rdata_n = cause_q;
        SLOT_MASK:  rdata_n = mask_q;
        default:    rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q <= irq_n;
      if (rd_en) rdata_q <= rdata_n;
    end
  end

  assign irq_o   = irq_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mcause_intc_chk.sv
module mcause_intc_chk
  import mcause_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic               sel_i,
  input logic               wr_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic [NUM_SRC-1:0] cause_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq_o,
  input logic [IDX_W-1:0]   pend_idx_o,
  input logic               pend_vld_o
);
  logic               live_q;
  logic               c_wr;
  logic               m_wr;
  logic [NUM_SRC-1:0] one;
  logic [NUM_SRC-1:0] pick_bit;
  logic [NUM_SRC-1:0] below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  always_comb begin
    c_wr     = sel_i & wr_i & (addr_i == 4'h0);
    m_wr     = sel_i & wr_i & (addr_i == 4'h4);
    one      = {{(NUM_SRC-1){1'b0}}, 1'b1};
    pick_bit = one << pend_idx_o;
    below    = pick_bit - one;
  end

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && m_wr) |=> (mask_q == $past(wdata_i)));

  assert_zero_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && c_wr) |=>
      ((cause_q & $past(cause_q & ~wdata_i)) == $past(cause_q & ~wdata_i)));

  assert_level_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> ((cause_q & $past(src_i)) == $past(src_i)));

  assert_irq_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> (irq_o == $past(pend_vld_o)));

  assert_pick_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld_o |-> ((cause_q & mask_q & pick_bit) != '0));

  assert_pick_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld_o |-> ((cause_q & mask_q & below) == '0));
endmodule

bind mcause_intc mcause_intc_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .src_i      (src_i),
  .sel_i      (sel_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .cause_q    (cause_q),
  .mask_q     (mask_q),
  .irq_o      (irq_o),
  .pend_idx_o (pend_idx_o),
  .pend_vld_o (pend_vld_o)
);

// File: tb/mcause_intc_tb.sv
module mcause_intc_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] src_i;
  logic        sel_i;
  logic        wr_i;
  logic [3:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic [4:0]  pend_idx_o;
  logic        pend_vld_o;

  int tests;
  int fails;

  mcause_intc dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .pend_idx_o (pend_idx_o),
    .pend_vld_o (pend_vld_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    sel_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    @(negedge clk);
    d = rdata_o;
    sel_i = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] p);
    @(negedge clk);
    src_i = p;
    @(negedge clk);
    src_i = '0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    tests = 0; fails = 0;
    rst_n = 1'b0; src_i = '0; sel_i = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 vld", {31'd0, pend_vld_o}, 32'd0);
    chk("R1 idx", {27'd0, pend_idx_o}, 32'd0);
    chk("R1 rdata", rdata_o, 32'd0);
    bus_rd(4'h0, rd); chk("R1 cause", rd, 32'd0);
    bus_rd(4'h4, rd); chk("R1 mask", rd, 32'd0);

    // R2 mask write/read
    bus_wr(4'h4, 32'hA5A5_0F0F); bus_rd(4'h4, rd); chk("R2 mask a", rd, 32'hA5A5_0F0F);
    bus_wr(4'h4, 32'hFFFF_FFFF); bus_rd(4'h4, rd); chk("R2 mask b", rd, 32'hFFFF_FFFF);

    // R7 unmapped / misaligned accesses
    bus_wr(4'hC, 32'h0000_0000); bus_wr(4'h8, 32'h0000_0000); bus_wr(4'h5, 32'h0);
    bus_rd(4'h4, rd); chk("R7 write ignored", rd, 32'hFFFF_FFFF);
    bus_rd(4'h8, rd); chk("R7 read 0x8", rd, 32'd0);
    bus_rd(4'h4, rd);
    bus_rd(4'hC, rd); chk("R7 read 0xC", rd, 32'd0);
    bus_rd(4'h4, rd);
    bus_rd(4'h6, rd); chk("R7 read misaligned", rd, 32'd0);
    bus_rd(4'h4, rd);
    repeat (2) @(negedge clk);
    chk("R7 rdata holds", rdata_o, 32'hFFFF_FFFF);

    // R4 R5 R6 single-line sweep, mask fully open
    for (int i = 0; i < 32; i++) begin
      pulse(32'd1 << i);
      chk("R6 vld single", {31'd0, pend_vld_o}, 32'd1);
      chk("R6 idx single", {27'd0, pend_idx_o}, i);
      chk("R5 irq lag", {31'd0, irq_o}, 32'd0);
      @(negedge clk);
      chk("R5 irq rise", {31'd0, irq_o}, 32'd1);
      bus_rd(4'h0, rd); chk("R4 cause single", rd, 32'd1 << i);
      bus_wr(4'h0, 32'd1 << i);
      chk("R5 irq fall lag", {31'd0, irq_o}, 32'd1);
      @(negedge clk);
      chk("R5 irq fall", {31'd0, irq_o}, 32'd0);
      chk("R3 ack clears", {31'd0, pend_vld_o}, 32'd0);
    end

    // R6 lowest-first with multi-bit patterns
    for (int i = 0; i < 32; i++) begin
      pulse((32'hC3A5_5A3D << i) | (32'd1 << i));
      chk("R6 idx lowest", {27'd0, pend_idx_o}, i);
      bus_wr(4'h0, 32'hFFFF_FFFF);
      chk("R6 vld cleared", {31'd0, pend_vld_o}, 32'd0);
    end

    // R6 mask gating does not alter cause
    bus_wr(4'h4, 32'h0000_000C);
    pulse(32'h0000_000E);
    chk("R6 masked idx", {27'd0, pend_idx_o}, 32'd2);
    bus_wr(4'h4, 32'h0);
    chk("R6 masked vld", {31'd0, pend_vld_o}, 32'd0);
    @(negedge clk);
    chk("R5 masked irq", {31'd0, irq_o}, 32'd0);
    bus_rd(4'h0, rd); chk("R6 cause kept", rd, 32'h0000_000E);
    bus_wr(4'h0, 32'hFFFF_FFFF);

    // R3 zero bits keep value, ones clear
    pulse(32'hF0F0_0000);
    bus_wr(4'h0, 32'h0); bus_rd(4'h0, rd); chk("R3 zero write", rd, 32'hF0F0_0000);
    bus_wr(4'h0, 32'h3030_0000); bus_rd(4'h0, rd); chk("R3 partial ack", rd, 32'hC0C0_0000);
    bus_wr(4'h0, 32'hFFFF_FFFF); bus_rd(4'h0, rd); chk("R3 full ack", rd, 32'h0);

    // R4 set wins while the level is held
    @(negedge clk); src_i = 32'h0000_0080;
    bus_wr(4'h0, 32'h0000_0080);
    bus_rd(4'h0, rd); chk("R4 set wins", rd, 32'h0000_0080);
    src_i = '0;
    bus_wr(4'h0, 32'h0000_0080);
    bus_rd(4'h0, rd); chk("R4 released ack", rd, 32'h0);

    // R8 shutdown sequence with one source still active
    bus_wr(4'h4, 32'hFFFF_FFFF);
    pulse(32'h0F00_0F00);
    @(negedge clk); src_i = 32'h0000_0008;
    @(negedge clk);
    chk("R8 irq before", {31'd0, irq_o}, 32'd1);
    bus_wr(4'h4, 32'h0);
    bus_wr(4'h0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 irq low", {31'd0, irq_o}, 32'd0);
    bus_rd(4'h0, rd); chk("R8 cause active only", rd, 32'h0000_0008);
    src_i = '0;
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, rd); chk("R8 cause empty", rd, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule